// File: doc/BRIEF.md
# Dual-Mode Oscillator Control Word Loader

This block builds a 40-bit configuration word for a numerically controlled oscillator core. The word can be written a byte at a time over an 8-bit bus, or one bit at a time through the top bit of that bus. Each write is marked by a rising edge on a write strobe. A rising edge on an update strobe then copies the assembled word into the applied registers that drive the oscillator: a 32-bit frequency word, a 5-bit phase word, a power-down flag and the current loading mode. Both strobes may be asynchronous. Each passes through a two-flop synchronizer and a rising-edge detector in the system clock domain.

After reset the block is in byte mode. Byte mode switches to bit mode when a word whose two control bits are both one is applied. A synchronous master-clear input clears the applied registers and the byte pointer. It leaves the assembly register alone, so a later update can still apply whatever was last written. Some control-bit patterns are reserved. An update that carries one of them raises an error pulse and changes nothing.

Top module: `tune_word_loader`

## Requirements
- R1: In byte mode, each write-strobe rising edge stores `din` into the byte slot chosen by a pointer and then advances the pointer. Slot 0 is {phase[4:0], power-down, ctrl[1:0]} from bit 7 down to bit 0. Slots 1 to 4 hold frequency bits 31:24, 23:16, 15:8 and 7:0.
- R2: Once five bytes have been stored, further write edges in byte mode leave the assembly register unchanged. This lasts until an update edge or a master clear returns the pointer to slot 0.
- R3: An update-strobe rising edge copies the assembled frequency, phase and power-down fields to the outputs and returns the pointer to slot 0.
- R4: In bit mode, each write edge shifts in `din[7]`. The bits arrive in this order: frequency bits 0 to 31, then ctrl[0], then ctrl[1], then power-down, then phase bits 0 to 4. After the 40th bit the word is complete and waits for an update edge.
- R5: An update applied in byte mode with ctrl = 2'b11 applies the word and switches to bit mode. `serial_mode` goes to 1 and stays at 1 until a master clear or a reset.
- R6: Reserved ctrl values are 2'b01 and 2'b10 in byte mode, and any nonzero value in bit mode. An update carrying a reserved value pulses `rsv_err` high for exactly one clock and leaves every applied output unchanged.
- R7: A high level of `mclr` at a clock edge clears frequency, phase, power-down and the pointer, and returns to byte mode. The assembly register keeps its contents.
- R8: An update that arrives before a full word has been written applies the assembly register as it currently stands.
- R9: When `rst_n` is low at a clock edge, every register is cleared, including the assembly register. All outputs then read zero.
- R10: An update-strobe rise that is set up before a clock edge changes the applied outputs at the third rising clock edge, counted from and including that edge.

Ports follow the port list of the top module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclr | input | 1 | Synchronous master clear, active high |
| wr_strobe | input | 1 | Write strobe, acts on its rising edge |
| upd_strobe | input | 1 | Update strobe, acts on its rising edge |
| din | input | 8 | Data bus; bit 7 carries the serial data |
| freq_word | output | 32 | Applied frequency word |
| phase_word | output | 5 | Applied phase word |
| power_down | output | 1 | Applied power-down flag |
| serial_mode | output | 1 | 1 when in bit (serial) loading mode |
| rsv_err | output | 1 | One-cycle pulse when a reserved ctrl value is rejected |

## Verification
Some properties are checked by assertions on every cycle. The pointer never goes past five. Writes to a full pointer leave the word unchanged. Update and master clear send the pointer home. Master clear clears the applied fields but never touches the assembly register. The error output is never high for two cycles in a row, and a rejected update leaves the outputs stable. Bit mode holds until a master clear. Other behaviour can only be shown by the bench's scenarios. These include the byte and bit orderings and the entry into bit mode through the control code. They also include early updates, the three-edge latency, and the fact that a reset clears the assembly register while a master clear does not.

// File: rtl/loader_pkg.sv
// Package: shared widths and the reserved-code rule for the control word loader.
// Assumes: the word is exactly NBYTES bus-wide bytes; the layout is {phase, pd, ctrl, freq}.
package loader_pkg;
    localparam int FREQ_W  = 32;
    localparam int PHASE_W = 5;
    localparam int CTRL_W  = 2;
    localparam int BUS_W   = 8;
    localparam int WORD_W  = FREQ_W + CTRL_W + 1 + PHASE_W;
    localparam int NBYTES  = WORD_W / BUS_W;
    localparam int PTR_W   = $clog2(NBYTES + 1);
    localparam int CTRL_LO = FREQ_W;
    localparam int PD_BIT  = FREQ_W + CTRL_W;
    localparam int PH_LO   = PD_BIT + 1;

    typedef enum logic {LOAD_PAR = 1'b0, LOAD_SER = 1'b1} load_mode_t;

    localparam logic [CTRL_W-1:0] CTRL_GO_SER = '1;

    // Decide whether a control pattern must be rejected in the given mode.
    function automatic logic ctrl_reserved(input load_mode_t m, input logic [CTRL_W-1:0] c);
        if (m == LOAD_SER) return (c != '0);
        return (c != '0) && (c != CTRL_GO_SER);
    endfunction
endpackage

// File: rtl/strobe_edge.sv
// Module: strobe_edge
// Brings an asynchronous strobe into the clk domain and emits a one-cycle pulse
// on each rising edge. Assumes: strobe high and low phases each last at least
// two clk periods so that no edge is lost.
module strobe_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic rise_pulse
);
    logic [SYNC_STAGES:0] sync_q;

    // Synchronizer chain plus one extra stage for the edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], strobe_in};
    end

    assign rise_pulse = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/word_assembler.sv
// Module: word_assembler
// Holds the 40-bit assembly register. In byte mode a pointer selects the slot
// written by each write pulse. In bit mode the whole register shifts right and
// takes the new bit at the top, so the first bit sent ends up at bit 0.
// Assumes: write and update pulses last one cycle; mclr never clears the register.
module word_assembler
    import loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclr,
    input  logic              wr_rise,
    input  logic              upd_rise,
    input  load_mode_t        mode,
    input  logic [BUS_W-1:0]  din,
    output logic [WORD_W-1:0] asm_word
);
    logic [PTR_W-1:0] ptr_q;
    logic [BUS_W-1:0] slot_q [NBYTES];
    logic             par_wr;

    assign par_wr = wr_rise && (mode == LOAD_PAR) && (ptr_q < PTR_W'(NBYTES));

    // Byte pointer: goes home on update or master clear, advances on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr || upd_rise) ptr_q <= '0;
        else if (par_wr)                ptr_q <= ptr_q + 1'b1;
    end

    for (genvar k = 0; k < NBYTES; k++) begin : g_slot
        logic shift_in;
        if (k == 0) begin : g_head
            assign shift_in = din[BUS_W-1];
        end else begin : g_link
            assign shift_in = slot_q[k-1][0];
        end

        // One slot: parallel store when selected, serial shift in bit mode.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[k] <= '0;
            else if (par_wr && ptr_q == PTR_W'(k))
                slot_q[k] <= din;
            else if (wr_rise && mode == LOAD_SER)
                slot_q[k] <= {shift_in, slot_q[k][BUS_W-1:1]};
        end

        assign asm_word[WORD_W-1-BUS_W*k -: BUS_W] = slot_q[k];
    end

    a_r2_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_W'(NBYTES));
    a_r2_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == PTR_W'(NBYTES) && wr_rise && mode == LOAD_PAR) |=> $stable(asm_word));
    a_r3_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_rise || mclr) |=> (ptr_q == '0));
    a_r7_asm_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mclr && !wr_rise) |=> $stable(asm_word));
endmodule

// File: rtl/word_applier.sv
// Module: word_applier
// Copies the assembly register into the applied registers on an update pulse,
// rejects reserved control patterns with a one-cycle error, and tracks the mode.
// Assumes: update pulses last one cycle; mclr takes priority over an update.
module word_applier
    import loader_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mclr,
    input  logic               upd_rise,
    input  logic [WORD_W-1:0]  asm_word,
    output logic [FREQ_W-1:0]  freq_q,
    output logic [PHASE_W-1:0] phase_q,
    output logic               pd_q,
    output load_mode_t         mode_q,
    output logic               err_q
);
    logic [CTRL_W-1:0] ctrl;
    logic              rsv;

    assign ctrl = asm_word[CTRL_LO +: CTRL_W];
    assign rsv  = ctrl_reserved(mode_q, ctrl);

    // Applied fields and mode: cleared by reset or master clear, loaded on a legal update.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            freq_q  <= '0;
            phase_q <= '0;
            pd_q    <= 1'b0;
            mode_q  <= LOAD_PAR;
        end else if (upd_rise && !rsv) begin
            freq_q  <= asm_word[FREQ_W-1:0];
            phase_q <= asm_word[PH_LO +: PHASE_W];
            pd_q    <= asm_word[PD_BIT];
            if (mode_q == LOAD_PAR && ctrl == CTRL_GO_SER) mode_q <= LOAD_SER;
        end
    end

    // Error pulse for a rejected update.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= upd_rise && rsv && !mclr;
    end

    a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);
    a_r6_hold_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_rise && rsv && !mclr) |=> ($stable(freq_q) && $stable(phase_q) && $stable(pd_q)));
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (freq_q == '0 && phase_q == '0 && !pd_q && mode_q == LOAD_PAR));
    a_r5_ser_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LOAD_SER && !mclr) |=> (mode_q == LOAD_SER));
endmodule

// File: rtl/tune_word_loader.sv
// Module: tune_word_loader (top)
// Two strobe edge detectors, the assembly register and the apply stage.
// Assumes: mclr and din are synchronous to clk; both strobes may be asynchronous.
module tune_word_loader
    import loader_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mclr,
    input  logic               wr_strobe,
    input  logic               upd_strobe,
    input  logic [BUS_W-1:0]   din,
    output logic [FREQ_W-1:0]  freq_word,
    output logic [PHASE_W-1:0] phase_word,
    output logic               power_down,
    output logic               serial_mode,
    output logic               rsv_err
);
    logic [1:0]        strobes;
    logic [1:0]        rises;
    logic [WORD_W-1:0] asm_word;
    load_mode_t        mode;

    assign strobes = {upd_strobe, wr_strobe};

    for (genvar s = 0; s < 2; s++) begin : g_edge
        strobe_edge #(.SYNC_STAGES(2)) u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .strobe_in (strobes[s]),
            .rise_pulse(rises[s])
        );
    end

    word_assembler u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mclr    (mclr),
        .wr_rise (rises[0]),
        .upd_rise(rises[1]),
        .mode    (mode),
        .din     (din),
        .asm_word(asm_word)
    );

    word_applier u_apply (
        .clk     (clk),
        .rst_n   (rst_n),
        .mclr    (mclr),
        .upd_rise(rises[1]),
        .asm_word(asm_word),
        .freq_q  (freq_word),
        .phase_q (phase_word),
        .pd_q    (power_down),
        .mode_q  (mode),
        .err_q   (rsv_err)
    );

    assign serial_mode = (mode == LOAD_SER);
endmodule

// File: tb/tune_word_loader_tb_top.sv
module tune_word_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mclr = 1'b0;
    logic        wr_s = 1'b0;
    logic        upd_s = 1'b0;
    logic [7:0]  din = '0;
    logic [31:0] freq_word;
    logic [4:0]  phase_word;
    logic        power_down, serial_mode, rsv_err;

    int total = 0;
    int bad = 0;
    int seen_err = 0;
    bit done = 0;

    logic [39:0] m_asm;
    int          m_ptr;
    bit          m_ser;
    logic [31:0] m_freq;
    logic [4:0]  m_phase;
    bit          m_pd;
    int          m_err;

    always #10 clk = ~clk;

    tune_word_loader dut_i (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .wr_strobe(wr_s), .upd_strobe(upd_s),
        .din(din), .freq_word(freq_word), .phase_word(phase_word),
        .power_down(power_down), .serial_mode(serial_mode), .rsv_err(rsv_err)
    );

    always @(negedge clk) if (rst_n && rsv_err) seen_err++;

    task automatic model_reset();
        m_asm = '0; m_ptr = 0; m_ser = 0; m_freq = '0; m_phase = '0; m_pd = 0; m_err = 0;
    endtask

    function automatic bit reserved_code(bit ser, logic [1:0] c);
        return ser ? (c != 2'b00) : (c == 2'b01 || c == 2'b10);
    endfunction

    task automatic check_val(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check_val(req, "freq", freq_word, m_freq);
        check_val(req, "phase", 32'(phase_word), 32'(m_phase));
        check_val(req, "pd", 32'(power_down), 32'(m_pd));
        check_val(req, "mode", 32'(serial_mode), 32'(m_ser));
        check_val(req, "errs", 32'(seen_err), 32'(m_err));
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); din = d; wr_s = 1'b1;
        repeat (4) @(negedge clk);
        wr_s = 1'b0;
        repeat (4) @(negedge clk);
        if (!m_ser) begin
            if (m_ptr < 5) begin m_asm[39-8*m_ptr -: 8] = d; m_ptr++; end
        end else begin
            m_asm = {d[7], m_asm[39:1]};
        end
    endtask

    task automatic model_update();
        logic [1:0] c;
        c = m_asm[33:32];
        m_ptr = 0;
        if (reserved_code(m_ser, c)) m_err++;
        else begin
            m_freq = m_asm[31:0]; m_phase = m_asm[39:35]; m_pd = m_asm[34];
            if (!m_ser && c == 2'b11) m_ser = 1;
        end
    endtask

    task automatic upd();
        @(negedge clk); upd_s = 1'b1;
        repeat (4) @(negedge clk);
        upd_s = 1'b0;
        repeat (4) @(negedge clk);
        model_update();
    endtask

    task automatic pulse_mclr();
        @(negedge clk); mclr = 1'b1;
        @(negedge clk); mclr = 1'b0;
        @(negedge clk);
        m_freq = '0; m_phase = '0; m_pd = 0; m_ptr = 0; m_ser = 0;
    endtask

    task automatic load_par(input logic [4:0] ph, input bit pd, input logic [1:0] c, input logic [31:0] f);
        wr({ph, pd, c});
        for (int i = 3; i >= 0; i--) wr(f[8*i +: 8]);
    endtask

    task automatic send_serial(input logic [39:0] w);
        for (int i = 0; i < 40; i++) wr({w[i], 7'b0});
    endtask

    function automatic logic [39:0] ser_word(logic [4:0] ph, bit pd, logic [1:0] c, logic [31:0] f);
        return {ph, pd, c, f};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 reset state");

        // R1/R3: directed byte load
        load_par(5'h15, 1'b0, 2'b00, 32'h1234_5678);
        upd();
        check_all("R1 R3 byte load");

        // R10: latency of an update edge
        load_par(5'h0A, 1'b1, 2'b00, 32'hCAFE_F00D);
        @(negedge clk); upd_s = 1'b1;
        @(negedge clk);
        check_val("R10", "freq before 2nd edge", freq_word, 32'h1234_5678);
        @(negedge clk);
        check_val("R10", "freq after 2 edges", freq_word, 32'h1234_5678);
        @(negedge clk);
        check_val("R10", "freq after 3 edges", freq_word, 32'hCAFE_F00D);
        repeat (2) @(negedge clk); upd_s = 1'b0;
        repeat (4) @(negedge clk);
        model_update();
        check_all("R10 applied");

        // R2: sixth byte ignored
        load_par(5'h03, 1'b0, 2'b00, 32'hA5A5_0F0F);
        wr(8'hFF);
        upd();
        check_all("R2 full pointer");

        // R8: early update after two bytes (pointer restarted at 0 by R3)
        wr({5'h1F, 1'b0, 2'b00});
        wr(8'h77);
        upd();
        check_all("R8 early update");

        // R6: reserved byte-mode codes
        wr({5'h02, 1'b1, 2'b01}); upd();
        check_all("R6 ctrl 01");
        wr({5'h04, 1'b0, 2'b10}); upd();
        check_all("R6 ctrl 10");

        // random byte-mode traffic
        for (int n = 0; n < 20; n++) begin
            int cnt;
            cnt = 1 + ($urandom % 6);
            for (int b = 0; b < cnt; b++) begin
                logic [7:0] d;
                d = 8'($urandom);
                if (b == 0 && d[1:0] == 2'b11) d[1:0] = 2'b00;
                wr(d);
            end
            upd();
            check_all("R1 R2 R6 random bytes");
        end

        // R7: master clear, assembly register kept
        load_par(5'h11, 1'b1, 2'b00, 32'h0BAD_BEEF);
        pulse_mclr();
        check_all("R7 after clear");
        upd();
        check_all("R7 assembly kept");

        // R5: enter bit mode
        load_par(5'h09, 1'b0, 2'b11, 32'h0000_1001);
        upd();
        check_all("R5 serial entry");

        // R4: serial words
        send_serial(ser_word(5'h13, 1'b0, 2'b00, 32'h8000_0001));
        upd();
        check_all("R4 serial directed");
        for (int n = 0; n < 5; n++) begin
            send_serial(ser_word(5'($urandom), 1'($urandom), 2'b00, $urandom));
            upd();
            check_all("R4 serial random");
        end
        send_serial(ser_word(5'h1E, 1'b1, 2'b11, 32'h1111_2222));
        upd();
        check_all("R6 serial reserved 11");
        send_serial(ser_word(5'h01, 1'b0, 2'b01, 32'h3333_4444));
        upd();
        check_all("R6 serial reserved 01");

        // R7: master clear leaves bit mode
        pulse_mclr();
        check_all("R7 back to byte mode");

        // R9: reset clears assembly register
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        model_reset(); seen_err = 0;
        @(negedge clk);
        check_all("R9 reset again");
        wr({5'h05, 1'b0, 2'b00});
        upd();
        check_all("R9 assembly cleared");

        finish_run();
    end
endmodule